// File: doc/BRIEF.md
# Charge and Discharge Activity Counter Bank

This block keeps four 16-bit tallies for a battery gauge. Two count charge quanta and two count elapsed time, one pair for the charging direction and one for the discharging direction. A two-bit sense-polarity input selects which pair may advance. A charge pulse input bumps the selected quantity counter. A time tick input, with one strobe per normal time count, bumps the selected time counter.

Each time counter has its own overflow flag. When the counter wraps, the flag changes state, and while the flag is set the counter moves only once every 256 ticks. A host reads and writes bytes over a plain register port, and it zeroes counters by writing ones into a clear register whose bits never persist. The host also uses the register port to preload counter bytes for maintenance.

Top module: `chg_tally_bank`

## Requirements
- R1: With `sense_pol` = 2'b01 (charging), a `charge_pulse` adds one to the charge quantity counter and a `time_tick` adds one to the charge time counter. Both discharge counters hold.
- R2: With `sense_pol` = 2'b10 (discharging), a `charge_pulse` adds one to the discharge quantity counter and a `time_tick` adds one to the discharge time counter. Both charge counters hold.
- R3: With `sense_pol` = 2'b00 or 2'b11, no counter moves on pulses or ticks.
- R4: While its flag is clear, a time counter advances by one on every qualifying tick.
- R5: A time counter wrapping from 0xFFFF to 0 while its flag is clear sets that flag. The flag sits in mode register bit 0 for discharge time and bit 1 for charge time. While the flag is set, the counter advances once per 256 qualifying ticks.
- R6: A second wrap, taken at the slow rate, clears the flag, and the counter then advances on every tick again.
- R7: A quantity counter wraps from 0xFFFF to 0 and touches no flag.
- R8: Writing the clear register (0x63) zeroes the counters whose bits are 1: bit 0 discharge quantity, bit 1 charge quantity, bit 2 discharge time, bit 3 charge time. The clear register always reads back 0.
- R9: Clearing a time counter also clears its flag and its prescaler, so the next tick advances it by one.
- R10: A clear and a hardware increment of the same counter in the same cycle leave the counter at zero.
- R11: The register map is as follows: discharge quantity 0x6E/0x6D (high/low), charge quantity 0x6C/0x6B, discharge time 0x68/0x67, charge time 0x66/0x65, mode 0x64, clear 0x63. `reg_rdata` presents the addressed byte in the cycle after `reg_re`. A host write to a counter byte loads that byte and takes priority over an increment. Writes to the mode register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sense_pol | input | 2 | 01 charging, 10 discharging, 00/11 idle |
| charge_pulse | input | 1 | One charge quantum, single cycle |
| time_tick | input | 1 | One normal-rate time count, single cycle |
| reg_addr | input | 7 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, registered |

## Verification
A host clear and a hardware increment of the same counter can fall in the same cycle. The bench provokes this by asserting `charge_pulse` and `time_tick` with charging polarity in the very cycle that writes the clear register for both charge counters. Both counters hold non-zero values before that cycle, and the bench judges the result by reading them back as zero while the discharge counters keep their values. The slow-rate window is checked separately: the bench preloads 0xFFFF through the register port and confirms that 255 ticks leave the counter unchanged and the 256th wraps it.

// File: rtl/tally_pkg.sv
package tally_pkg;
  localparam int CNT_W    = 16;
  localparam int DIV_LOG2 = 8;

  localparam logic [6:0] ADDR_CLR   = 7'h63;
  localparam logic [6:0] ADDR_MODE  = 7'h64;
  localparam logic [6:0] ADDR_CTC_L = 7'h65;
  localparam logic [6:0] ADDR_CTC_H = 7'h66;
  localparam logic [6:0] ADDR_DTC_L = 7'h67;
  localparam logic [6:0] ADDR_DTC_H = 7'h68;
  localparam logic [6:0] ADDR_CCR_L = 7'h6B;
  localparam logic [6:0] ADDR_CCR_H = 7'h6C;
  localparam logic [6:0] ADDR_DCR_L = 7'h6D;
  localparam logic [6:0] ADDR_DCR_H = 7'h6E;

  typedef enum logic [1:0] {
    POL_IDLE = 2'b00,
    POL_CHG  = 2'b01,
    POL_DIS  = 2'b10,
    POL_BAD  = 2'b11
  } pol_e;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] cur);
    return cur + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] load_byte(input logic [CNT_W-1:0] cur,
                                                 input logic hi,
                                                 input logic [7:0] b);
    logic [CNT_W-1:0] r;
    r = cur;
    if (hi) r[15:8] = b;
    else    r[7:0]  = b;
    return r;
  endfunction
endpackage

// File: rtl/tally_qty_ctr.sv
module tally_qty_ctr
  import tally_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] cnt
);
  logic wr_any;
  assign wr_any = wr_lo | wr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (wr_any) cnt <= load_byte(cnt, wr_hi, wdata);
    else if (step)   cnt <= bump(cnt);
  end

  // R8
  qty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  // R3
  qty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr && !wr_any) |=> $stable(cnt));
  // R7
  qty_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !wr_any && cnt == '1) |=> cnt == '0);
endmodule

// File: rtl/tally_time_ctr.sv
module tally_time_ctr
  import tally_pkg::*;
#(
  parameter int DL = DIV_LOG2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             slow
);
  logic [DL-1:0] presc;
  logic          wr_any, presc_full, adv_evt, wrap_evt;

  assign wr_any     = wr_lo | wr_hi;
  assign presc_full = (presc == '1);
  assign adv_evt    = step && (!slow || presc_full) && !wr_any;
  assign wrap_evt   = adv_evt && (cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt   <= '0;
      slow  <= 1'b0;
      presc <= '0;
    end else begin
      if (wr_any)       cnt <= load_byte(cnt, wr_hi, wdata);
      else if (adv_evt) cnt <= bump(cnt);
      if (wrap_evt) begin
        slow  <= !slow;
        presc <= '0;
      end else if (step && slow) begin
        presc <= presc + 1'b1;
      end
    end
  end

  // R9
  time_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !slow));
  // R5
  flag_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && wrap_evt) |=> slow != $past(slow));
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wrap_evt) |=> $stable(slow));
  // R5
  slow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && slow && !presc_full && !clr && !wr_any) |=> $stable(cnt));
  // R4
  fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !slow && !clr && !wr_any && cnt != '1) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/chg_tally_bank.sv
module chg_tally_bank
  import tally_pkg::*;
#(
  parameter int DL = DIV_LOG2
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sense_pol,
  input  logic       charge_pulse,
  input  logic       time_tick,
  input  logic [6:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  input  logic       reg_re,
  output logic [7:0] reg_rdata
);
  localparam int NDIR = 2;

  logic [3:0]       clr_vec;
  logic [NDIR-1:0]  dir_on, slow;
  logic [CNT_W-1:0] q_cnt [NDIR];
  logic [CNT_W-1:0] t_cnt [NDIR];
  logic [7:0]       rd_mux;

  assign clr_vec = (reg_we && reg_addr == ADDR_CLR) ? reg_wdata[3:0] : 4'h0;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    localparam logic [6:0] QL = (d == 0) ? ADDR_DCR_L : ADDR_CCR_L;
    localparam logic [6:0] QH = (d == 0) ? ADDR_DCR_H : ADDR_CCR_H;
    localparam logic [6:0] TL = (d == 0) ? ADDR_DTC_L : ADDR_CTC_L;
    localparam logic [6:0] TH = (d == 0) ? ADDR_DTC_H : ADDR_CTC_H;
    localparam pol_e       PD = (d == 0) ? POL_DIS : POL_CHG;

    assign dir_on[d] = (sense_pol == PD);

    tally_qty_ctr u_qty (
      .clk(clk), .rst_n(rst_n),
      .step(dir_on[d] && charge_pulse),
      .clr(clr_vec[d]),
      .wr_lo(reg_we && reg_addr == QL),
      .wr_hi(reg_we && reg_addr == QH),
      .wdata(reg_wdata),
      .cnt(q_cnt[d])
    );

    tally_time_ctr #(.DL(DL)) u_time (
      .clk(clk), .rst_n(rst_n),
      .step(dir_on[d] && time_tick),
      .clr(clr_vec[2+d]),
      .wr_lo(reg_we && reg_addr == TL),
      .wr_hi(reg_we && reg_addr == TH),
      .wdata(reg_wdata),
      .cnt(t_cnt[d]),
      .slow(slow[d])
    );
  end

  always_comb begin
    case (reg_addr)
      ADDR_DCR_L: rd_mux = q_cnt[0][7:0];
      ADDR_DCR_H: rd_mux = q_cnt[0][15:8];
      ADDR_CCR_L: rd_mux = q_cnt[1][7:0];
      ADDR_CCR_H: rd_mux = q_cnt[1][15:8];
      ADDR_DTC_L: rd_mux = t_cnt[0][7:0];
      ADDR_DTC_H: rd_mux = t_cnt[0][15:8];
      ADDR_CTC_L: rd_mux = t_cnt[1][7:0];
      ADDR_CTC_H: rd_mux = t_cnt[1][15:8];
      ADDR_MODE:  rd_mux = {6'b0, slow};
      default:    rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= 8'h00;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  // R1 R2 R3
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_on[1] && clr_vec[1] == 1'b0 && !(reg_we && (reg_addr == ADDR_CCR_L || reg_addr == ADDR_CCR_H)))
      |=> $stable(q_cnt[1]));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> $stable(reg_rdata));
endmodule

// File: tb/chg_tally_bank_test.sv
module chg_tally_bank_test;
  localparam int PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] sense_pol = 2'b00;
  logic       charge_pulse = 0, time_tick = 0;
  logic [6:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic       reg_we = 0, reg_re = 0;
  logic [7:0] reg_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  chg_tally_bank uut (
    .clk(clk), .rst_n(rst_n), .sense_pol(sense_pol),
    .charge_pulse(charge_pulse), .time_tick(time_tick),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  typedef struct packed {
    logic [1:0] pol;
    logic [3:0] np, nt, e_dq, e_cq, e_dt, e_ct;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{2'b01, 4'd3, 4'd2, 4'd0, 4'd3, 4'd0, 4'd2},
    '{2'b10, 4'd4, 4'd5, 4'd4, 4'd0, 4'd5, 4'd0},
    '{2'b00, 4'd2, 4'd3, 4'd0, 4'd0, 4'd0, 4'd0},
    '{2'b11, 4'd5, 4'd1, 4'd0, 4'd0, 4'd0, 4'd0},
    '{2'b01, 4'd1, 4'd0, 4'd0, 4'd1, 4'd0, 4'd0},
    '{2'b10, 4'd0, 4'd3, 4'd0, 4'd0, 4'd3, 4'd0}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] v);
    reg_addr = a; reg_re = 1;
    @(negedge clk);
    reg_re = 0;
    v = reg_rdata;
  endtask

  task automatic rd16(input logic [6:0] lo, output int v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 7'd1, h);
    v = {h, l};
  endtask

  task automatic run(input logic [1:0] pol, input int np, input int nt, input int n);
    sense_pol = pol;
    for (int i = 0; i < n; i++) begin
      charge_pulse = (i < np);
      time_tick = (i < nt);
      @(negedge clk);
    end
    charge_pulse = 0; time_tick = 0; sense_pol = 2'b00;
  endtask

  task automatic wr16(input logic [6:0] lo, input logic [15:0] v);
    wr(lo, v[7:0]);
    wr(lo + 7'd1, v[15:8]);
  endtask

  initial begin
    #(PERIOD*150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got hang expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, dq, cq, dt, ct, n;
    logic [7:0] b;
    dq = 0; cq = 0; dt = 0; ct = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    rd16(7'h6D, v); chk("R11 reset dq", v, 0);
    rd16(7'h6B, v); chk("R11 reset cq", v, 0);
    rd16(7'h67, v); chk("R11 reset dt", v, 0);
    rd16(7'h65, v); chk("R11 reset ct", v, 0);
    rd(7'h64, b);   chk("R11 reset mode", b, 0);

    // R1 R2 R3 R4 table walk
    for (int k = 0; k < NV; k++) begin
      n = (TBL[k].np > TBL[k].nt) ? TBL[k].np : TBL[k].nt;
      run(TBL[k].pol, TBL[k].np, TBL[k].nt, n);
      dq += TBL[k].e_dq; cq += TBL[k].e_cq;
      dt += TBL[k].e_dt; ct += TBL[k].e_ct;
      rd16(7'h6D, v); chk("R2 R3 dq table", v, dq);
      rd16(7'h6B, v); chk("R1 R3 cq table", v, cq);
      rd16(7'h67, v); chk("R2 R4 dt table", v, dt);
      rd16(7'h65, v); chk("R1 R4 ct table", v, ct);
    end

    // R8 selective clear, self-resetting
    wr(7'h63, 8'h01);
    rd16(7'h6D, v); chk("R8 dq cleared", v, 0);
    rd16(7'h6B, v); chk("R8 cq kept", v, cq);
    rd(7'h63, b);   chk("R8 clear reads 0", b, 0);

    // R10 clear collides with increments
    sense_pol = 2'b01; charge_pulse = 1; time_tick = 1;
    reg_addr = 7'h63; reg_wdata = 8'h0A; reg_we = 1;
    @(negedge clk);
    reg_we = 0; charge_pulse = 0; time_tick = 0; sense_pol = 2'b00;
    rd16(7'h6B, v); chk("R10 cq clear wins", v, 0);
    rd16(7'h65, v); chk("R10 ct clear wins", v, 0);
    rd16(7'h67, v); chk("R10 dt untouched", v, dt);

    // R7 quantity wrap
    wr16(7'h6B, 16'hFFFF);
    rd16(7'h6B, v); chk("R11 cq preload", v, 16'hFFFF);
    run(2'b01, 1, 0, 1);
    rd16(7'h6B, v); chk("R7 cq wrap", v, 0);
    rd(7'h64, b);   chk("R7 no flag", b, 0);

    // R11 mode write ignored
    wr(7'h64, 8'hFF);
    rd(7'h64, b);   chk("R11 mode write ignored", b, 0);

    // R5 first wrap of charge time
    wr16(7'h65, 16'hFFFF);
    run(2'b01, 0, 1, 1);
    rd16(7'h65, v); chk("R5 ct wrap", v, 0);
    rd(7'h64, b);   chk("R5 ct flag set", b, 2);
    wr16(7'h65, 16'hFFFF);
    run(2'b01, 0, 255, 255);
    rd16(7'h65, v); chk("R5 slow hold 255", v, 16'hFFFF);
    rd(7'h64, b);   chk("R5 flag kept", b, 2);
    // R6 second wrap
    run(2'b01, 0, 1, 1);
    rd16(7'h65, v); chk("R6 second wrap", v, 0);
    rd(7'h64, b);   chk("R6 flag cleared", b, 0);
    run(2'b01, 0, 1, 1);
    rd16(7'h65, v); chk("R6 normal rate", v, 1);

    // R9 clear restores rate
    wr16(7'h65, 16'hFFFF);
    run(2'b01, 0, 1, 1);
    run(2'b01, 0, 3, 3);
    rd16(7'h65, v); chk("R9 slow before clear", v, 0);
    rd(7'h64, b);   chk("R9 flag before clear", b, 2);
    wr(7'h63, 8'h08);
    rd(7'h64, b);   chk("R9 flag cleared", b, 0);
    run(2'b01, 0, 1, 1);
    rd16(7'h65, v); chk("R9 normal rate", v, 1);

    // R5 discharge-time flag in bit 0
    wr16(7'h67, 16'hFFFF);
    run(2'b10, 0, 1, 1);
    rd16(7'h67, v); chk("R5 dt wrap", v, 0);
    rd(7'h64, b);   chk("R5 dt flag bit0", b, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule